// File: doc/BRIEF.md
# Edge-Selected Timestamp Capture Channel

This block records when something happened outside the chip. It watches a single external capture pin. When the channel is armed and the chosen transition arrives on that pin, the block stores the current value of the real-time counter's fine time window. The fine window is the 32-bit slice of the counter that advances in 8 µs steps.

The capture pin is brought into the clock domain through a synchronizer before its edges are detected. A configuration bit chooses whether rising or falling transitions count as captures. Software drives the channel through one-bit register writes:

- an arm-set write arms the channel;
- an arm-clear write disarms it;
- a configuration write selects the edge.

The stored value is read back through a 32-bit register in which only the low 21 bits are kept. Each capture raises a one-cycle event pulse for the interrupt logic. A read of the capture register sends a one-cycle request to drop the channel's raw status.

Top module: `tstamp_capture`

## Requirements
- R1: After reset the channel is unarmed, the rising edge is selected (`edge_fall` = 0), `cap_value` is 0, and both `cap_evt` and `stat_drop` are 0.
- R2: A configuration write (`cfg_we` = 1) copies `wbit` into the edge select. 0 selects rising edges and 1 selects falling edges. Only the selected edge direction causes a capture.
- R3: An arm-set write with `wbit` = 1 sets `armed` on the next clock. An arm-set write with `wbit` = 0 has no effect, and setting an already armed channel keeps it armed.
- R4: An arm-clear write with `wbit` = 1 clears `armed` on the next clock without raising an event. An arm-clear write with `wbit` = 0 has no effect. When set and clear are written in the same cycle, clear wins.
- R5: While armed, a selected edge on `cap_pin` raises `cap_evt` for exactly one cycle. It also latches `fine_time` as sampled at that same clock edge. This happens on the third rising clock edge after the pin changes (two synchronizer stages plus one edge-detect stage).
- R6: An edge of the unselected direction, or any edge while unarmed, leaves `cap_value` unchanged and raises no event.
- R7: `cap_value` holds `fine_time[20:0]` in bits [20:0], and bits [31:21] always read 0.
- R8: An arm-clear write that lands on the same clock edge as a capture still lets that capture through, with its event and stored value. The channel is unarmed afterwards.
- R9: A read strobe `cap_rd` produces a one-cycle `stat_drop` pulse on the following clock, whether or not the channel is armed.
- R10: A later capture overwrites the value stored by an earlier one. The channel stays armed between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fine_time | input | 32 | Fine window of the real-time counter |
| cap_pin | input | 1 | External capture source, asynchronous |
| arm_set_we | input | 1 | Write strobe for the arm-set bit |
| arm_clr_we | input | 1 | Write strobe for the arm-clear bit |
| cfg_we | input | 1 | Write strobe for the edge-select bit |
| wbit | input | 1 | Data bit for whichever write strobe is active |
| cap_rd | input | 1 | Read strobe for the capture register |
| armed | output | 1 | Arm status, readable through both arm registers |
| edge_fall | output | 1 | Current edge select: 1 means falling |
| cap_value | output | 32 | Captured time, low 21 bits kept |
| cap_evt | output | 1 | One-cycle capture event pulse |
| stat_drop | output | 1 | One-cycle request to clear the raw capture status |

## Verification
The bench builds the block with its default parameters: a 32-bit fine window, 21 kept bits and two synchronizer stages. The three-cycle pin-to-event latency in R5 is checked against that depth. Because the window is wider than the kept field, capture times with ones above bit 20 show that the upper bits are dropped. A table walks rising and falling selections, armed and unarmed, through captures and through edges that must be ignored. Directed tests then cover the same-edge disarm and the set/clear collision.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tsc_edge.sv
module tsc_edge
  import tsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_sel_e sel,
  output logic      edge_hit
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    edge_hit = (sel == EDGE_FALL) ? fall : rise;
  end
endmodule

// File: rtl/tsc_arm.sv
module tsc_arm
  import tsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_we,
  input  logic      clr_we,
  input  logic      cfg_we,
  input  logic      wbit,
  output logic      armed,
  output edge_sel_e sel
);
  logic      armed_q, armed_d;
  edge_sel_e sel_q, sel_d;
  logic      arm_en, sel_en;

  always_comb begin
    armed_d = armed_q;
    if (set_we && wbit && !armed_q) armed_d = 1'b1;
    if (clr_we && wbit)             armed_d = 1'b0;
    arm_en  = (set_we | clr_we) & wbit;
    sel_d   = edge_sel_e'(wbit);
    sel_en  = cfg_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (arm_en) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= EDGE_RISE;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign armed = armed_q;
  assign sel   = sel_q;
endmodule

// File: rtl/tsc_store.sv
module tsc_store #(
  parameter int FINE_W = 32,
  parameter int KEEP_W = 21,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [FINE_W-1:0] fine_time,
  input  logic              rd,
  output logic [OUT_W-1:0]  cap_value,
  output logic              cap_evt,
  output logic              stat_drop
);
  localparam int PAD_W = OUT_W - KEEP_W;

  logic [KEEP_W-1:0] val_q, val_d;
  logic              evt_q, evt_d;
  logic              drop_q, drop_d;
  logic              unused_hi;

  assign unused_hi = ^fine_time[FINE_W-1:KEEP_W];

  always_comb begin
    val_d  = fine_time[KEEP_W-1:0];
    evt_d  = hit;
    drop_d = rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (hit) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      drop_q <= drop_d;
    end
  end

  assign cap_value = {{PAD_W{1'b0}}, val_q};
  assign cap_evt   = evt_q;
  assign stat_drop = drop_q;
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tsc_pkg::*;
#(
  parameter int FINE_W      = 32,
  parameter int KEEP_W      = 21,
  parameter int OUT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FINE_W-1:0] fine_time,
  input  logic              cap_pin,
  input  logic              arm_set_we,
  input  logic              arm_clr_we,
  input  logic              cfg_we,
  input  logic              wbit,
  input  logic              cap_rd,
  output logic              armed,
  output logic              edge_fall,
  output logic [OUT_W-1:0]  cap_value,
  output logic              cap_evt,
  output logic              stat_drop
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  logic       pin_s;
  logic       edge_hit;
  logic       hit;
  edge_sel_e  sel;

  // Reset asserts immediately and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(cap_pin), .q(pin_s)
  );

  tsc_arm u_arm (
    .clk(clk), .rst_n(rst_q_n), .set_we(arm_set_we), .clr_we(arm_clr_we),
    .cfg_we(cfg_we), .wbit(wbit), .armed(armed), .sel(sel)
  );

  tsc_edge u_edge (
    .clk(clk), .rst_n(rst_q_n), .lvl(pin_s), .sel(sel), .edge_hit(edge_hit)
  );

  // The arm state is sampled before a same-edge clear takes effect.
  assign hit = armed & edge_hit;

  tsc_store #(.FINE_W(FINE_W), .KEEP_W(KEEP_W), .OUT_W(OUT_W)) u_store (
    .clk(clk), .rst_n(rst_q_n), .hit(hit), .fine_time(fine_time), .rd(cap_rd),
    .cap_value(cap_value), .cap_evt(cap_evt), .stat_drop(stat_drop)
  );

  assign edge_fall = (sel == EDGE_FALL);
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_set_we,
  input logic             arm_clr_we,
  input logic             wbit,
  input logic             cap_rd,
  input logic             armed,
  input logic [OUT_W-1:0] cap_value,
  input logic             cap_evt,
  input logic             stat_drop
);
  assert_set_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set_we && wbit && !(arm_clr_we && wbit)) |=> armed);

  assert_clr_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr_we && wbit) |=> !armed);

  assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);

  assert_evt_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> $past(armed));

  assert_value_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |-> $stable(cap_value));

  assert_read_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd |=> stat_drop);

  assert_drop_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_drop && !$past(cap_rd, 1)) |-> 1'b0);
endmodule

bind tstamp_capture tsc_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .arm_set_we(arm_set_we), .arm_clr_we(arm_clr_we),
  .wbit(wbit), .cap_rd(cap_rd), .armed(armed), .cap_value(cap_value),
  .cap_evt(cap_evt), .stat_drop(stat_drop)
);

// File: tb/sim_tstamp_capture.sv
module sim_tstamp_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {fall_sel, arm, to_level, expect_hit, time[31:0]}
  localparam logic [35:0] VECS [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1234},
    {1'b1, 1'b1, 1'b0, 1'b1, 32'h0001_ABCD},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0777},
    {1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0999},
    {1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0555},
    {1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fine_time;
  logic        cap_pin, arm_set_we, arm_clr_we, cfg_we, wbit, cap_rd;
  logic        armed, edge_fall, cap_evt, stat_drop;
  logic [31:0] cap_value;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_capture u0 (
    .clk(clk), .rst_n(rst_n), .fine_time(fine_time), .cap_pin(cap_pin),
    .arm_set_we(arm_set_we), .arm_clr_we(arm_clr_we), .cfg_we(cfg_we),
    .wbit(wbit), .cap_rd(cap_rd), .armed(armed), .edge_fall(edge_fall),
    .cap_value(cap_value), .cap_evt(cap_evt), .stat_drop(stat_drop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic b);
    arm_set_we = (which == 0);
    arm_clr_we = (which == 1);
    cfg_we     = (which == 2);
    wbit       = b;
    @(negedge clk);
    arm_set_we = 0; arm_clr_we = 0; cfg_we = 0; wbit = 0;
  endtask

  task automatic settle_pin(input logic lvl);
    cap_pin = lvl;
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] prev;
    rst_n = 0; fine_time = 0; cap_pin = 0; arm_set_we = 0; arm_clr_we = 0;
    cfg_we = 0; wbit = 0; cap_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 armed", {31'd0, armed}, 0);
    chk("R1 edge", {31'd0, edge_fall}, 0);
    chk("R1 value", cap_value, 0);
    chk("R1 evt", {31'd0, cap_evt}, 0);
    chk("R1 drop", {31'd0, stat_drop}, 0);

    // Vector table: R2, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      wr(1, 1'b1);
      settle_pin(~VECS[i][33]);
      wr(2, VECS[i][35]);
      chk("R2 edge select", {31'd0, edge_fall}, {31'd0, VECS[i][35]});
      if (VECS[i][34]) wr(0, 1'b1);
      fine_time = VECS[i][31:0];
      prev = cap_value;
      cap_pin = VECS[i][33];
      repeat (2) @(negedge clk);
      chk("R5 no early evt", {31'd0, cap_evt}, 0);
      @(negedge clk);
      chk(VECS[i][32] ? "R5 evt" : "R6 no evt", {31'd0, cap_evt}, {31'd0, VECS[i][32]});
      chk(VECS[i][32] ? "R7 value" : "R6 value kept", cap_value,
          VECS[i][32] ? {11'd0, VECS[i][20:0]} : prev);
      @(negedge clk);
      chk("R5 single pulse", {31'd0, cap_evt}, 0);
    end

    // R3 / R4 directed
    wr(1, 1'b1);
    wr(0, 1'b0);
    chk("R3 set write 0", {31'd0, armed}, 0);
    wr(0, 1'b1);
    chk("R3 set write 1", {31'd0, armed}, 1);
    wr(0, 1'b1);
    chk("R3 set while armed", {31'd0, armed}, 1);
    wr(1, 1'b0);
    chk("R4 clear write 0", {31'd0, armed}, 1);
    arm_set_we = 1; arm_clr_we = 1; wbit = 1;
    @(negedge clk);
    arm_set_we = 0; arm_clr_we = 0; wbit = 0;
    chk("R4 clear wins", {31'd0, armed}, 0);

    // R10 overwrite with two rising captures
    wr(2, 1'b0);
    settle_pin(1'b0);
    wr(0, 1'b1);
    fine_time = 32'h0000_0011;
    cap_pin = 1;
    repeat (3) @(negedge clk);
    chk("R10 first", cap_value, 32'h11);
    settle_pin(1'b0);
    fine_time = 32'h0000_0022;
    cap_pin = 1;
    repeat (3) @(negedge clk);
    chk("R10 overwrite", cap_value, 32'h22);
    chk("R10 still armed", {31'd0, armed}, 1);

    // R8 clear on the capture edge
    settle_pin(1'b0);
    fine_time = 32'h0000_0033;
    cap_pin = 1;
    repeat (2) @(negedge clk);
    wr(1, 1'b1);
    chk("R8 evt", {31'd0, cap_evt}, 1);
    chk("R8 value", cap_value, 32'h33);
    chk("R8 unarmed", {31'd0, armed}, 0);

    // R9 read pulse
    cap_rd = 1;
    @(negedge clk);
    cap_rd = 0;
    chk("R9 drop", {31'd0, stat_drop}, 1);
    @(negedge clk);
    chk("R9 drop single", {31'd0, stat_drop}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule